// File: doc/BRIEF.md
# SPI Register Access Slave

This block sits between a four-wire SPI bus and the register file of a UART. The bus master frames each transaction by pulling chip select low. The first byte it shifts in, most significant bit first, is a command byte. That byte gives the transfer direction, one of sixteen register indices, and a two-bit channel field. The bytes that follow are data, also sent most significant bit first. SPI mode 0 is used: the slave samples on the rising edge of the serial clock and changes its output after the falling edge.

The serial pins are synchronised into the system clock domain and their edges are detected there. The block issues single-cycle write strobes carrying the address and data. It issues read strobes that tell the register file a byte has been taken. During one chip-select window, every extra data byte goes to the same register again, so a master can fill or drain a FIFO in one burst. A command whose channel field is not zero is discarded. A byte cut short by chip select going high has no effect.

The states are IDLE, CMD, SKIP, FETCH, RDATA and WDATA. Chip select high moves any state to IDLE.
- IDLE goes to CMD when chip select goes low.
- CMD goes to SKIP when the channel field is nonzero, to FETCH on a valid read, and to WDATA on a valid write.
- FETCH goes to RDATA after one cycle.
- RDATA goes back to FETCH when each byte completes.
- WDATA and SKIP hold until chip select rises.

Top module: `spireg_slave`

## Requirements
- R1: After reset, and whenever chip select is high, no strobe is issued and `spi_miso` is 0.
- R2: A command byte with bit 7 = 0 and bits 2:1 = 00 selects register bits 6:3 for writing. After the 8th rising clock edge of the next byte, one `reg_wr_stb` pulse carries that address and the byte on `reg_wr_data`.
- R3: A command byte with bit 7 = 1 and bits 2:1 = 00 produces one `reg_rd_stb` right after the command byte. `reg_rd_data` is taken in the same cycle. Its bit 7 is on `spi_miso` before the first data rising edge, and each falling edge moves to the next lower bit.
- R4: A command byte with bits 2:1 other than 00 produces no strobe for the rest of the transaction, and `spi_miso` stays 0.
- R5: Each further complete byte in a write transaction produces another `reg_wr_stb` to the same address.
- R6: In a read transaction, the next byte is loaded from `reg_rd_data` when the previous byte completes. It is committed with a `reg_rd_stb` only at the first rising edge of that next byte, so a burst that ends on a byte boundary takes no extra byte.
- R7: When chip select rises in the middle of a byte, that byte issues no strobe. The next transaction is decoded from its own first bit.
- R8: Each strobe lasts exactly one cycle, and the read and write strobes are never high together.
- R9: Bit 0 of the command byte has no effect on the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| reg_addr | output | 4 | Register index for both strobes |
| reg_wr_stb | output | 1 | One-cycle write strobe |
| reg_wr_data | output | 8 | Write data, valid with `reg_wr_stb` |
| reg_rd_stb | output | 1 | One-cycle read-commit strobe |
| reg_rd_data | input | 8 | Current value of the addressed register |

## Verification
The hardest case to create is a burst read that stops exactly on a byte boundary. In that case the next byte has already been loaded into the shifter but must not be committed. The bench pushes three bytes into a FIFO model behind the register port and drains two of them in one burst. It then reads the level register to confirm that only two bytes left the FIFO, and finally reads the third byte. Aborts are forced by raising chip select after a few bits of a command byte and of a data byte. After each abort, the bench checks that register contents and strobe counts have not changed.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = $clog2(BYTE_W);
    localparam int DIR_BIT  = 7;
    localparam int ADDR_HI  = 6;
    localparam int ADDR_LO  = 3;
    localparam int CH_HI    = 2;
    localparam int CH_LO    = 1;
    localparam int ADDR_W   = ADDR_HI - ADDR_LO + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_SKIP,
        ST_FETCH,
        ST_RDATA,
        ST_WDATA
    } spi_state_e;
endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spireg_shift.sv
module spireg_shift
    import spireg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic              din,
    input  logic              shift,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val,
    output logic              dout
);
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sr;
    logic [BYTE_W-1:0] tx_sr;

    assign byte_done = sample && (bit_cnt == CNT_W'(BYTE_W - 1));
    assign byte_val  = {rx_sr[BYTE_W-2:0], din};
    assign dout      = tx_sr[BYTE_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
        end else if (clear) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
        end else if (sample) begin
            rx_sr   <= byte_val;
            bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        tx_sr <= '0;
        else if (clear)                    tx_sr <= '0;
        else if (load)                     tx_sr <= load_val;
        else if (shift && bit_cnt != '0)   tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
    end
endmodule

// File: rtl/spireg_fsm.sv
module spireg_fsm
    import spireg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_hi,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] byte_val,
    output spi_state_e        state,
    output logic              sample,
    output logic              tx_shift,
    output logic              tx_load,
    output logic              miso_en,
    output logic [ADDR_W-1:0] addr,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_stb
);
    spi_state_e nxt;
    logic       ch_ok;
    logic       is_rd;
    logic       commit_pend;

    assign ch_ok    = (byte_val[CH_HI:CH_LO] == '0);
    assign is_rd    = byte_val[DIR_BIT];
    assign sample   = sclk_rise && !cs_hi &&
                      (state == ST_CMD || state == ST_WDATA || state == ST_RDATA);
    assign tx_shift = sclk_fall && !cs_hi && (state == ST_RDATA);
    assign tx_load  = (state == ST_FETCH);
    assign miso_en  = (state == ST_RDATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (cs_hi) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  nxt = ST_CMD;
                ST_CMD:   if (byte_done) nxt = !ch_ok ? ST_SKIP : (is_rd ? ST_FETCH : ST_WDATA);
                ST_FETCH: nxt = ST_RDATA;
                ST_RDATA: if (byte_done) nxt = ST_FETCH;
                ST_WDATA: nxt = ST_WDATA;
                ST_SKIP:  nxt = ST_SKIP;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr        <= '0;
            wr_stb      <= 1'b0;
            wr_data     <= '0;
            rd_stb      <= 1'b0;
            commit_pend <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            rd_stb <= 1'b0;
            if (cs_hi) begin
                commit_pend <= 1'b0;
            end else begin
                if (state == ST_CMD && byte_done && ch_ok) begin
                    addr   <= byte_val[ADDR_HI:ADDR_LO];
                    rd_stb <= is_rd;
                end
                if (state == ST_WDATA && byte_done) begin
                    wr_stb  <= 1'b1;
                    wr_data <= byte_val;
                end
                if (state == ST_RDATA && byte_done) begin
                    commit_pend <= 1'b1;
                end
                if (state == ST_RDATA && sample && commit_pend) begin
                    rd_stb      <= 1'b1;
                    commit_pend <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/spireg_slave.sv
module spireg_slave
    import spireg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr_stb,
    output logic [BYTE_W-1:0] reg_wr_data,
    output logic              reg_rd_stb,
    input  logic [BYTE_W-1:0] reg_rd_data
);
    localparam int         N_PINS   = 3;
    localparam logic [2:0] SYNC_RST = 3'b001;

    logic [N_PINS-1:0] pins_raw;
    logic [N_PINS-1:0] pins_s;
    logic              cs_hi;
    logic              sclk_s;
    logic              sclk_d;
    logic              mosi_s;
    logic              sclk_rise;
    logic              sclk_fall;

    spi_state_e        state;
    logic              sample;
    logic              tx_shift;
    logic              tx_load;
    logic              miso_en;
    logic              byte_done;
    logic [BYTE_W-1:0] byte_val;
    logic              tx_bit;

    assign pins_raw = {spi_mosi, spi_sclk, spi_cs_n};

    for (genvar g = 0; g < N_PINS; g++) begin : g_sync
        spireg_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (SYNC_RST[g])
        ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (pins_raw[g]),
            .q     (pins_s[g])
        );
    end

    assign cs_hi  = pins_s[0];
    assign sclk_s = pins_s[1];
    assign mosi_s = pins_s[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;

    spireg_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_hi     (cs_hi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .byte_done (byte_done),
        .byte_val  (byte_val),
        .state     (state),
        .sample    (sample),
        .tx_shift  (tx_shift),
        .tx_load   (tx_load),
        .miso_en   (miso_en),
        .addr      (reg_addr),
        .wr_stb    (reg_wr_stb),
        .wr_data   (reg_wr_data),
        .rd_stb    (reg_rd_stb)
    );

    spireg_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cs_hi),
        .sample    (sample),
        .din       (mosi_s),
        .shift     (tx_shift),
        .load      (tx_load),
        .load_val  (reg_rd_data),
        .byte_done (byte_done),
        .byte_val  (byte_val),
        .dout      (tx_bit)
    );

    assign spi_miso = miso_en & tx_bit;
endmodule

// File: rtl/spireg_slave_chk.sv
module spireg_slave_chk
    import spireg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_hi,
    input spi_state_e        state,
    input logic              rd_stb,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] addr
);
    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && wr_stb));

    // R8
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> !rd_stb);

    // R8
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R7
    cs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> !(rd_stb || wr_stb));

    // R4
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |=> !(rd_stb || wr_stb));

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA) |=> (state != ST_WDATA) || $stable(addr));

    // R3
    rd_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (state == ST_RDATA || state == ST_IDLE));
endmodule

bind spireg_slave spireg_slave_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_hi  (cs_hi),
    .state  (state),
    .rd_stb (reg_rd_stb),
    .wr_stb (reg_wr_stb),
    .addr   (reg_addr)
);

// File: tb/spireg_slave_bench.sv
`timescale 1ns/1ps
module spireg_slave_bench;
    localparam int HALF = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       mosi = 1'b0;
    logic       miso;
    logic [3:0] addr;
    logic       wr_stb;
    logic [7:0] wr_data;
    logic       rd_stb;
    logic [7:0] rd_data;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    spireg_slave u_spireg_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_cs_n    (cs_n),
        .spi_sclk    (sclk),
        .spi_mosi    (mosi),
        .spi_miso    (miso),
        .reg_addr    (addr),
        .reg_wr_stb  (wr_stb),
        .reg_wr_data (wr_data),
        .reg_rd_stb  (rd_stb),
        .reg_rd_data (rd_data)
    );

    // register file model: index 0 is a FIFO, index 9 reports its level
    logic [7:0] regs [16];
    logic [7:0] fifo [64];
    logic [5:0] rp, wp;
    logic [6:0] lvl;
    int wr_cnt, rd_cnt, overlap_cnt, long_cnt;
    logic wr_q, rd_q;

    assign rd_data = (addr == 4'd0) ? fifo[rp] :
                     (addr == 4'd9) ? {1'b0, lvl} : regs[addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) regs[i] <= 8'h00;
            rp <= '0; wp <= '0; lvl <= '0;
            wr_cnt <= 0; rd_cnt <= 0; overlap_cnt <= 0; long_cnt <= 0;
            wr_q <= 1'b0; rd_q <= 1'b0;
        end else begin
            wr_q <= wr_stb;
            rd_q <= rd_stb;
            if (wr_stb && rd_stb) overlap_cnt <= overlap_cnt + 1;
            if ((wr_stb && wr_q) || (rd_stb && rd_q)) long_cnt <= long_cnt + 1;
            if (wr_stb) begin
                wr_cnt <= wr_cnt + 1;
                if (addr == 4'd0) begin
                    fifo[wp] <= wr_data;
                    wp  <= wp + 1'b1;
                    lvl <= lvl + 1'b1;
                end else begin
                    regs[addr] <= wr_data;
                end
            end
            if (rd_stb) begin
                rd_cnt <= rd_cnt + 1;
                if (addr == 4'd0 && lvl != 0) begin
                    rp  <= rp + 1'b1;
                    lvl <= lvl - 1'b1;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] cmd(input logic rd, input logic [3:0] r,
                                       input logic [1:0] ch, input logic b0);
        return {rd, r, ch, b0};
    endfunction

    task automatic spi_begin();
        cs_n = 1'b0;
        #(HALF);
    endtask

    task automatic spi_end();
        #(HALF);
        cs_n = 1'b1;
        #(4 * HALF);
    endtask

    task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = tx[i];
            #(HALF);
            rx[i] = miso;
            sclk = 1'b1;
            #(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic spi_write(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] rx;
        spi_begin();
        spi_bits(c, 8, rx);
        spi_bits(d, 8, rx);
        spi_end();
    endtask

    task automatic spi_read1(input logic [7:0] c, output logic [7:0] d);
        logic [7:0] rx;
        spi_begin();
        spi_bits(c, 8, rx);
        spi_bits(8'h00, 8, d);
        spi_end();
    endtask

    task automatic t_reset();
        chk("R1 miso idle", miso, 0);
        chk("R1 no write strobes", wr_cnt, 0);
        chk("R1 no read strobes", rd_cnt, 0);
    endtask

    task automatic t_write_read();
        logic [7:0] d;
        int w0, r0;
        w0 = wr_cnt; r0 = rd_cnt;
        spi_write(cmd(0, 4'd5, 2'b00, 0), 8'hA5);
        chk("R2 reg5 written", regs[5], 8'hA5);
        chk("R2 one write strobe", wr_cnt - w0, 1);
        spi_read1(cmd(1, 4'd5, 2'b00, 0), d);
        chk("R3 read data msb first", d, 8'hA5);
        chk("R3 one read strobe", rd_cnt - r0, 1);
        chk("R1 miso low after cs high", miso, 0);
    endtask

    task automatic t_bit0();
        logic [7:0] d;
        spi_write(cmd(0, 4'd6, 2'b00, 1), 8'h3C);
        chk("R9 write with bit0 set", regs[6], 8'h3C);
        spi_read1(cmd(1, 4'd6, 2'b00, 1), d);
        chk("R9 read with bit0 set", d, 8'h3C);
    endtask

    task automatic t_bad_channel();
        logic [7:0] d;
        int w0, r0;
        w0 = wr_cnt; r0 = rd_cnt;
        spi_write(cmd(0, 4'd5, 2'b01, 0), 8'h11);
        spi_write(cmd(0, 4'd5, 2'b11, 0), 8'h22);
        chk("R4 reg unchanged", regs[5], 8'hA5);
        chk("R4 no write strobe", wr_cnt - w0, 0);
        spi_read1(cmd(1, 4'd5, 2'b10, 0), d);
        chk("R4 miso held low", d, 8'h00);
        chk("R4 no read strobe", rd_cnt - r0, 0);
    endtask

    task automatic t_abort();
        logic [7:0] rx;
        int w0;
        w0 = wr_cnt;
        spi_begin();
        spi_bits(cmd(0, 4'd5, 2'b00, 0), 8, rx);
        spi_bits(8'hFF, 4, rx);
        spi_end();
        chk("R7 partial data byte dropped", wr_cnt - w0, 0);
        chk("R7 reg unchanged", regs[5], 8'hA5);
        spi_begin();
        spi_bits(8'hFF, 3, rx);
        spi_end();
        spi_write(cmd(0, 4'd7, 2'b00, 0), 8'h5A);
        chk("R7 next transaction decoded", regs[7], 8'h5A);
        chk("R7 single strobe after abort", wr_cnt - w0, 1);
    endtask

    task automatic t_burst();
        logic [7:0] rx, d0, d1;
        int w0, r0;
        w0 = wr_cnt;
        spi_begin();
        spi_bits(cmd(0, 4'd0, 2'b00, 0), 8, rx);
        spi_bits(8'h11, 8, rx);
        spi_bits(8'h22, 8, rx);
        spi_bits(8'h33, 8, rx);
        spi_end();
        chk("R5 three write strobes", wr_cnt - w0, 3);
        spi_read1(cmd(1, 4'd9, 2'b00, 0), rx);
        chk("R5 fifo level 3", rx, 8'h03);
        r0 = rd_cnt;
        spi_begin();
        spi_bits(cmd(1, 4'd0, 2'b00, 0), 8, rx);
        spi_bits(8'h00, 8, d0);
        spi_bits(8'h00, 8, d1);
        spi_end();
        chk("R6 first burst byte", d0, 8'h11);
        chk("R6 second burst byte", d1, 8'h22);
        chk("R6 two commits", rd_cnt - r0, 2);
        spi_read1(cmd(1, 4'd9, 2'b00, 0), rx);
        chk("R6 no byte lost at boundary", rx, 8'h01);
        spi_read1(cmd(1, 4'd0, 2'b00, 0), rx);
        chk("R6 remaining byte", rx, 8'h33);
    endtask

    initial begin
        #(2_000_000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #3;
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #3;
        t_reset();
        t_write_read();
        t_bit0();
        t_bad_channel();
        t_abort();
        t_burst();
        chk("R8 strobes never together", overlap_cnt, 0);
        chk("R8 strobes one cycle wide", long_cnt, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule